// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Sequencer

The block sits between a clocked host and an external 32K x 8 asynchronous static RAM. The host hands over one word at a time through a request/ready handshake: a 15-bit address, a write flag and, for writes, a data byte. The block turns each request into a strobe sequence on the RAM's active-low chip select, write enable and output enable lines. That sequence meets the RAM's minimum pulse, setup and overlap times, plus the time the RAM needs to release its outputs. Read results come back on a read-data port together with a one-cycle valid pulse.

The shared data bus is modelled as three plain ports: an output byte, an input byte and a drive enable, and the tristate buffer sits outside the block. All strobe and bus-enable outputs come straight from flops, so the RAM never sees a decode glitch. Every wait count is worked out during elaboration from nanosecond timing parameters and the clock period, rounding up, with at least one cycle for each count. At the default 8 ns clock:

- A write keeps the host waiting for 9 cycles.
- A read keeps the host waiting for 10 cycles.

When no request is pending, the RAM is left deselected (standby) with every strobe high and the bus not driven.

Top module: `sram_strobe_ctl`

## Requirements
- R1: After reset and whenever no request is in progress, req_ready is 1, mem_cs_n, mem_we_n and mem_oe_n are all 1, and mem_dq_oe is 0.
- R2: A request is taken on a rising clock edge where req_valid and req_ready are both 1. req_ready then stays 0 for 9 cycles for a write or 10 cycles for a read (default timing), and then returns to 1.
- R3: In a write, mem_cs_n falls with the address one cycle before mem_we_n falls, and mem_oe_n stays 1 for the whole write.
- R4: The write window (mem_cs_n and mem_we_n both 0) lasts at least the write-pulse count: the largest of the rounded-up write pulse (45 ns), select-to-end (50 ns), address-to-end (50 ns) and data setup (25 ns), and no less than the write cycle (55 ns) minus two cycles.
- R5: mem_addr and mem_dq_out do not change while the write window is open. mem_dq_oe and mem_dq_out hold for one more cycle after mem_we_n rises, so the written byte is the request's data.
- R6: In a read, mem_cs_n and mem_oe_n stay 0 for the access count: the largest of the rounded-up access (55 ns), output-enable-to-valid (30 ns) and read cycle (55 ns). mem_dq_in is then registered into rd_data, and rd_valid is 1 for exactly one cycle, seven cycles after acceptance by default.
- R7: After a read, the block does not assert mem_dq_oe until the release count (20 ns, rounded up) has passed since mem_oe_n rose.
- R8: mem_dq_oe is never 1 while mem_oe_n is 0. mem_we_n is 0 only while mem_oe_n is 1, mem_cs_n is 0 and mem_dq_oe is 1.
- R9: Each count is ceil(time_ns * 1000 / CLK_PS), with a minimum of 1. At CLK_PS = 8000 this gives a write window of exactly 7 cycles, a read access of 7 cycles and a release of 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | One-cycle pulse when rd_data is new |
| mem_addr | output | 15 | RAM address bus |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_dq_out | output | 8 | Byte driven onto the shared data bus |
| mem_dq_in | input | 8 | Byte read from the shared data bus |
| mem_dq_oe | output | 1 | Enable for the external data-bus tristate |

## Verification
The hardest case to reach from the ports is a write that follows a read as early as possible, while the RAM may still be driving the shared bus during its release time. To reach it, the bench keeps req_valid high with a write queued right behind a read, so the write is taken on the first idle cycle. The bench's behavioural RAM keeps driving for the release time after its output enable rises, and flags any cycle in which both sides drive the bus. The same model rejects short write windows, address or data movement inside a window, and read data sampled before the access time has passed.

// File: rtl/sram_strobe_pkg.sv
package sram_strobe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_ADDR,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_RD_ACCESS,
        ST_RD_RELEASE
    } seq_state_e;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } strobe_t;

    localparam strobe_t STROBE_STANDBY = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

    // ceil(t_ns * 1000 / clk_ps), never below one cycle
    function automatic int ns_to_cyc(input int t_ns, input int clk_ps);
        int c;
        c = (t_ns * 1000 + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic strobe_t strobes_for(input seq_state_e s);
        strobe_t st;
        st = STROBE_STANDBY;
        case (s)
            ST_WR_ADDR:   st = '{cs_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
            ST_WR_PULSE:  st = '{cs_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, dq_oe: 1'b1};
            ST_WR_HOLD:   st = '{cs_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b1};
            ST_RD_ACCESS: st = '{cs_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, dq_oe: 1'b0};
            default:      st = STROBE_STANDBY;
        endcase
        return st;
    endfunction

endpackage

// File: rtl/sram_wait_cnt.sv
module sram_wait_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/sram_seq.sv
module sram_seq
    import sram_strobe_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int PULSE_CYC = 7,
    parameter int ACC_CYC   = 7,
    parameter int REL_CYC   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             cnt_done,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_val,
    output seq_state_e       state_next,
    output logic             ready,
    output logic             accept,
    output logic             capture
);
    localparam logic [CNT_W-1:0] PULSE_M1 = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] ACC_M1   = CNT_W'(ACC_CYC - 1);
    localparam logic [CNT_W-1:0] REL_M1   = CNT_W'(REL_CYC - 1);

    seq_state_e state;

    always_comb begin
        state_next = state;
        cnt_load   = 1'b0;
        cnt_val    = '0;
        case (state)
            ST_IDLE: if (req_valid) begin
                if (req_write) begin
                    state_next = ST_WR_ADDR;
                end else begin
                    state_next = ST_RD_ACCESS;
                    cnt_load   = 1'b1;
                    cnt_val    = ACC_M1;
                end
            end
            ST_WR_ADDR: begin
                state_next = ST_WR_PULSE;
                cnt_load   = 1'b1;
                cnt_val    = PULSE_M1;
            end
            ST_WR_PULSE:  if (cnt_done) state_next = ST_WR_HOLD;
            ST_WR_HOLD:   state_next = ST_IDLE;
            ST_RD_ACCESS: if (cnt_done) begin
                state_next = ST_RD_RELEASE;
                cnt_load   = 1'b1;
                cnt_val    = REL_M1;
            end
            ST_RD_RELEASE: if (cnt_done) state_next = ST_IDLE;
            default: state_next = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_next;
    end

    assign ready   = (state == ST_IDLE);
    assign accept  = ready && req_valid;
    assign capture = (state == ST_RD_ACCESS) && cnt_done;

    // R2
    leave_idle_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> !ready);
    // R6
    capture_from_read_chk: assert property (@(posedge clk) disable iff (rst)
        capture |=> (state == ST_RD_RELEASE));
endmodule

// File: rtl/sram_strobe_reg.sv
module sram_strobe_reg
    import sram_strobe_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  seq_state_e state_next,
    output strobe_t    strobes
);
    always_ff @(posedge clk) begin
        if (rst) strobes <= STROBE_STANDBY;
        else     strobes <= strobes_for(state_next);
    end

    // R8
    we_needs_select_chk: assert property (@(posedge clk) disable iff (rst)
        !strobes.we_n |-> (!strobes.cs_n && strobes.oe_n));
endmodule

// File: rtl/sram_strobe_ctl.sv
module sram_strobe_ctl
    import sram_strobe_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int DATA_W   = 8,
    parameter int CLK_PS   = 8000,
    parameter int T_WP_NS  = 45,
    parameter int T_CW_NS  = 50,
    parameter int T_AW_NS  = 50,
    parameter int T_DW_NS  = 25,
    parameter int T_WC_NS  = 55,
    parameter int T_AA_NS  = 55,
    parameter int T_OE_NS  = 30,
    parameter int T_RC_NS  = 55,
    parameter int T_REL_NS = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);
    localparam int WC_FLOOR  = max_of(ns_to_cyc(T_WC_NS, CLK_PS) - 2, 1);
    localparam int PULSE_CYC = max_of(max_of(ns_to_cyc(T_WP_NS, CLK_PS), ns_to_cyc(T_CW_NS, CLK_PS)),
                                      max_of(max_of(ns_to_cyc(T_AW_NS, CLK_PS), ns_to_cyc(T_DW_NS, CLK_PS)),
                                             WC_FLOOR));
    localparam int ACC_CYC   = max_of(max_of(ns_to_cyc(T_AA_NS, CLK_PS), ns_to_cyc(T_OE_NS, CLK_PS)),
                                      ns_to_cyc(T_RC_NS, CLK_PS));
    localparam int REL_CYC   = ns_to_cyc(T_REL_NS, CLK_PS);
    localparam int CNT_W     = $clog2(max_of(max_of(PULSE_CYC, ACC_CYC), REL_CYC) + 1);

    logic             cnt_load, cnt_done, accept, capture;
    logic [CNT_W-1:0] cnt_val;
    seq_state_e       state_next;
    strobe_t          strobes;

    sram_wait_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val), .done(cnt_done)
    );

    sram_seq #(
        .CNT_W(CNT_W), .PULSE_CYC(PULSE_CYC), .ACC_CYC(ACC_CYC), .REL_CYC(REL_CYC)
    ) u_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .cnt_done(cnt_done), .cnt_load(cnt_load), .cnt_val(cnt_val),
        .state_next(state_next), .ready(req_ready), .accept(accept), .capture(capture)
    );

    sram_strobe_reg u_strobe (
        .clk(clk), .rst(rst), .state_next(state_next), .strobes(strobes)
    );

    assign mem_cs_n  = strobes.cs_n;
    assign mem_we_n  = strobes.we_n;
    assign mem_oe_n  = strobes.oe_n;
    assign mem_dq_oe = strobes.dq_oe;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr <= req_addr;
            if (req_write) mem_dq_out <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= capture;
            if (capture) rd_data <= mem_dq_in;
        end
    end

    // R1
    idle_standby_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe));
    // R8
    no_contention_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_dq_oe);
    // R5
    addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && !mem_we_n) |=> (mem_we_n || ($stable(mem_addr) && $stable(mem_dq_out))));
    // R5
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (mem_dq_oe && !mem_cs_n && $stable(mem_dq_out)));
    // R6
    rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);
endmodule

// File: tb/test_sram_strobe_ctl.sv
`timescale 1ns/1ps
module test_sram_strobe_ctl;
    // Timing expectations at an 8 ns clock, written out from the requirements
    localparam int WIN_CYC   = 7;   // R4/R9 write window
    localparam int ACC_CYC   = 7;   // R6/R9 read access
    localparam int REL_CYC   = 3;   // R7/R9 release
    localparam int DSET_CYC  = 4;   // ceil(25/8)
    localparam int WR_BUSY   = 9;   // R2
    localparam int RD_BUSY   = 10;  // R2

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic req_ready, rd_valid, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  rd_data, mem_dq_out, mem_dq_in;
    logic [14:0] mem_addr;

    always #4 clk = ~clk;

    sram_strobe_ctl i_sram_strobe_ctl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural RAM ----------------
    logic [7:0] ram [int];
    logic [7:0] ram_q = 8'h5A;
    bit         ram_valid = 0;
    bit         win_prev = 0, cs_prev = 1;
    int         win_cnt = 0, dstab = 0, rd_cnt = 0, drive_hold = 0;
    logic [14:0] win_addr = '0, rd_addr = '0;
    logic [7:0]  last_d = '0;

    assign mem_dq_in = mem_dq_oe ? mem_dq_out : (ram_valid ? ram_q : 8'h5A);

    always @(negedge clk) begin
        bit win, ram_en;
        if (!rst) begin
            win    = !mem_cs_n && !mem_we_n;
            ram_en = !mem_cs_n && mem_we_n && !mem_oe_n;
            if (win) begin
                if (!win_prev) begin
                    win_addr = mem_addr; win_cnt = 1;
                    chk(!cs_prev, "R3 select low before write", cs_prev, 0);
                    chk(mem_oe_n, "R3 oe high during write", mem_oe_n, 1);
                end else begin
                    win_cnt++;
                    chk(mem_addr == win_addr, "R5 address moved in window", mem_addr, win_addr);
                end
                if (mem_dq_oe && mem_dq_out == last_d && win_cnt > 1) dstab++;
                else dstab = mem_dq_oe ? 1 : 0;
                last_d = mem_dq_out;
            end else if (win_prev) begin
                chk(win_cnt >= WIN_CYC, "R4 write window too short", win_cnt, WIN_CYC);
                chk(win_cnt == WIN_CYC, "R9 write window count", win_cnt, WIN_CYC);
                chk(dstab >= DSET_CYC, "R5 data setup", dstab, DSET_CYC);
                chk(mem_dq_oe && mem_dq_out == last_d, "R5 data hold", {mem_dq_oe, mem_dq_out}, {1'b1, last_d});
                ram[int'(win_addr)] = last_d;
            end
            if (ram_en) drive_hold = REL_CYC;
            else if (drive_hold > 0) drive_hold--;
            if (mem_dq_oe)
                chk(!(ram_en || drive_hold > 0), "R7/R8 bus contention", drive_hold, 0);
            if (ram_en && mem_addr == rd_addr) rd_cnt++;
            else rd_cnt = ram_en ? 1 : 0;
            rd_addr   = mem_addr;
            ram_valid = (rd_cnt >= ACC_CYC);
            ram_q     = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 8'h00;
            win_prev  = win;
            cs_prev   = mem_cs_n;
        end
    end

    // ---------------- reference model, compared every clock ----------------
    logic [7:0] ref_mem [int];
    logic [7:0] exp_q [$];
    int  busy = 0, rv = -1;
    bit  pend = 0, pend_wr = 0;
    logic [14:0] pend_addr;
    logic [7:0]  pend_data;

    always @(negedge clk) begin
        if (rst) begin
            busy = 0; rv = -1; pend = 0;
        end else begin
            if (busy > 0) busy--;
            if (rv >= 0) rv--;
            if (pend) begin
                busy = pend_wr ? WR_BUSY : RD_BUSY;
                if (pend_wr) ref_mem[int'(pend_addr)] = pend_data;
                else begin
                    rv = ACC_CYC;
                    exp_q.push_back(ref_mem.exists(int'(pend_addr)) ? ref_mem[int'(pend_addr)] : 8'h00);
                end
            end
            chk(req_ready == (busy == 0), "R2 ready timing", req_ready, busy == 0);
            chk(rd_valid == (rv == 0), "R6 rd_valid timing", rd_valid, rv == 0);
            if (rv == 0 && exp_q.size() > 0) begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(rd_data == e, "R6 read data", rd_data, e);
            end
            if (busy == 0)
                chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 standby strobes",
                    {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
            pend      = req_valid && req_ready;
            pend_wr   = req_write;
            pend_addr = req_addr;
            pend_data = req_wdata;
        end
    end

    // ---------------- stimulus ----------------
    task automatic issue(input bit w, input logic [14:0] a, input logic [7:0] d);
        bit hit;
        @(posedge clk); #2;
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        forever begin
            @(negedge clk); hit = req_ready;
            @(posedge clk); #2;
            if (hit) break;
        end
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(req_ready, "R1 ready after reset", req_ready, 1);
        chk(mem_cs_n && mem_we_n && mem_oe_n, "R1 strobes after reset", {mem_cs_n, mem_we_n, mem_oe_n}, 3'b111);
        chk(!mem_dq_oe && !rd_valid, "R1 bus idle after reset", {mem_dq_oe, rd_valid}, 0);
        // R3/R4/R5 writes at the address extremes
        issue(1, 15'h0000, 8'hA1);
        issue(1, 15'h7FFF, 8'hB2);
        issue(1, 15'h1234, 8'hC3);
        idle(5);
        // R6 reads back, and a never-written location
        issue(0, 15'h0000, 8'h00);
        issue(0, 15'h7FFF, 8'h00);
        issue(0, 15'h0001, 8'h00);
        // R7 write taken on the first idle cycle after a read
        issue(0, 15'h1234, 8'h00);
        issue(1, 15'h1234, 8'h3C);
        issue(0, 15'h1234, 8'h00);
        // overwrite and all-zero / all-one data
        issue(1, 15'h0055, 8'hFF);
        issue(1, 15'h0055, 8'h00);
        issue(0, 15'h0055, 8'h00);
        // mixed pattern
        for (int i = 0; i < 48; i++) begin
            logic [14:0] a;
            a = 15'((i * 1237) & 15'h7FFF);
            issue(1, a, 8'((i * 37) + 11));
            if (i % 3 == 0) idle(i % 4);
            issue(0, a, 8'h00);
        end
        idle(20);
        chk(exp_q.size() == 0, "R6 all reads returned", exp_q.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule